// File: doc/BRIEF.md
# Multi-Mode Register-Mapped Hash Engine

This block is a hashing peripheral on a plain 32-bit register bus. Software picks one of three digests (SHA-256, SHA-224 or SHA-1) in a control word. It starts a hash and then writes message words into a 64-byte input window. Each time sixteen words have arrived, the engine compresses that block by itself, one round per clock. A final-round command pads the last partial block using the running byte count, compresses one or two more blocks and leaves the digest in the hash register bank.

The running chaining state is visible between blocks and can be written back. Together with the writable byte count, this lets software suspend a long hash, run another one, and later resume the first. Reads of the hash bank can be byte-swapped. Two request flags report when the input window can take data and when a digest is waiting. They are only gated by enable bits and drive no transfer logic.

Register map, byte addresses on `addr`: control at 0x00, byte count at 0x04, hash words 0..7 at 0x40..0x5C, input window at 0x80..0xBF. Reads of any other address return 0.

Top module: `sha_engine`

## Requirements
- R1: After reset, the control word, the byte count, every hash word and both request flags read 0.
- R2: A control write with bit 0 set while idle and with byte count 0 loads the standard initial chaining values for the mode given in bits 5:4 of the same write. The mode codes are 0 for SHA-256, 1 for SHA-224, and 2 or 3 for SHA-1. With byte count nonzero, the state is left as it is.
- R3: While idle, every write to any address in 0x80..0xBF, including unaligned ones, appends the word at block word index count[5:2] and adds 4 to the byte count. The first message byte of a word sits in bits 31:24.
- R4: The write that fills word 15 starts compression at once. Control bit 0 then reads 1 for exactly 64 clock cycles per block in SHA-256/224 mode and 80 in SHA-1 mode.
- R5: While control bit 0 reads 1, writes to the window, the count, the hash bank and the control word have no effect.
- R6: A control write with bits 0 and 1 both set, while idle, pads the message and compresses it. Padding puts a 0x80 byte at byte position count mod 64, then zero bytes, then the 64-bit big-endian bit length (8 × count). If fewer than 8 bytes remain after the 0x80, a second length-only block follows. Bit 1 reads 1 until the digest is ready.
- R7: In SHA-1 mode, hash words 5..7 read 0. After a SHA-224 final round, hash word 7 reads 0. The other words give the standard digest, word 0 first.
- R8: Control bit 3 set makes hash reads return each state word as a 32-bit value. Clear, it returns the same word byte-reversed. Hash writes use the same order.
- R9: The byte count is writable while idle. A write sets both the pad position and the encoded length, and the count keeps its value after the final round.
- R10: Reading the eight state words and the count at a block boundary, running an unrelated hash, and then writing them back gives the same digest as an uninterrupted hash.
- R11: `in_dma_req` is high when control bits 2 and 9 are both set and the engine is idle. `out_dma_req` is high when control bit 10 is set and a digest is waiting. A later window or hash write clears the waiting digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| in_dma_req | output | 1 | Input window can take data |
| out_dma_req | output | 1 | Digest is waiting |

## Verification
Every mode is run on three messages with published digests: empty, three bytes and 56 bytes. These cover a pad block holding only padding, a partial word that needs a count override, and a pad that overflows into an extra length block. Each run also measures the busy time of the final round. A 128-byte message hashed straight through is compared with the same message suspended after its first block, interleaved with another hash, and restored. This separates correct state save and restore from an accidental reload of initial values. Window writes go to shifting and unaligned offsets, and writes made during compression are checked for having no effect.

// File: rtl/sha_engine.sv
module sha_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        in_dma_req,
  output logic        out_dma_req
);
  localparam int BLK_WORDS   = 16;
  localparam int ST_WORDS    = 8;
  localparam int RND_SHA1    = 80;
  localparam int RND_SHA2    = 64;
  localparam int BLK_BYTES   = BLK_WORDS * 4;
  localparam int LEN_BYTE0   = BLK_BYTES - 8;

  localparam logic [255:0] IV_256 =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;
  localparam logic [255:0] IV_224 =
    256'hc1059ed8_367cd507_3070dd17_f70e5939_ffc00b31_68581511_64f98fa7_befa4fa4;
  localparam logic [255:0] IV_160 =
    256'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0_00000000_00000000_00000000;

  localparam logic [31:0] K256 [RND_SHA2] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] iv_word(input logic [1:0] m, input int i);
    logic [255:0] t;
    t = m[1] ? IV_160 : (m[0] ? IV_224 : IV_256);
    return t[255 - 32*i -: 32];
  endfunction

  logic [31:0] blk  [BLK_WORDS];
  logic [31:0] pblk [BLK_WORDS];
  logic [31:0] st   [ST_WORDS];
  logic [31:0] v    [ST_WORDS];
  logic [31:0] vn   [ST_WORDS];
  logic [31:0] count;
  logic [6:0]  rnd;
  logic        running, fin, extra, done;
  logic [1:0]  mode;
  logic        big, in_en, fifo_en, out_en;

  logic        sha1, last;
  logic        sel_ctrl, sel_cnt, sel_hash, sel_win;
  logic [5:0]  rem;
  logic [63:0] bitlen;
  logic [31:0] wnew, ft, kt, t1, t2, hw, hraw;
  logic [7:0]  pb;

  assign sha1     = mode[1];
  assign last     = rnd == (sha1 ? 7'(RND_SHA1 - 1) : 7'(RND_SHA2 - 1));
  assign sel_ctrl = addr == 8'h00;
  assign sel_cnt  = addr == 8'h04;
  assign sel_hash = addr[7:5] == 3'b010 && addr[1:0] == 2'b00;
  assign sel_win  = addr[7:6] == 2'b10;
  assign rem      = count[5:0];
  assign bitlen   = {29'd0, count, 3'd0};

  assign in_dma_req  = in_en & fifo_en & ~running;
  assign out_dma_req = out_en & done & ~running;

  always_comb begin
    ft = 32'h0;
    kt = 32'h0;
    t1 = 32'h0;
    t2 = 32'h0;
    vn = v;
    if (sha1) begin
      wnew = rotr(blk[13] ^ blk[8] ^ blk[2] ^ blk[0], 31);
      if (rnd < 7'd20) begin
        ft = (v[1] & v[2]) | (~v[1] & v[3]);
        kt = 32'h5a827999;
      end else if (rnd < 7'd40) begin
        ft = v[1] ^ v[2] ^ v[3];
        kt = 32'h6ed9eba1;
      end else if (rnd < 7'd60) begin
        ft = (v[1] & v[2]) | (v[1] & v[3]) | (v[2] & v[3]);
        kt = 32'h8f1bbcdc;
      end else begin
        ft = v[1] ^ v[2] ^ v[3];
        kt = 32'hca62c1d6;
      end
      vn[0] = rotr(v[0], 27) + ft + v[4] + kt + blk[0];
      vn[1] = v[0];
      vn[2] = rotr(v[1], 2);
      vn[3] = v[2];
      vn[4] = v[3];
    end else begin
      wnew = (rotr(blk[14], 17) ^ rotr(blk[14], 19) ^ (blk[14] >> 10)) + blk[9]
           + (rotr(blk[1], 7) ^ rotr(blk[1], 18) ^ (blk[1] >> 3)) + blk[0];
      t1 = v[7] + (rotr(v[4], 6) ^ rotr(v[4], 11) ^ rotr(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + K256[rnd[5:0]] + blk[0];
      t2 = (rotr(v[0], 2) ^ rotr(v[0], 13) ^ rotr(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      vn[0] = t1 + t2;
      vn[1] = v[0];
      vn[2] = v[1];
      vn[3] = v[2];
      vn[4] = v[3] + t1;
      vn[5] = v[4];
      vn[6] = v[5];
      vn[7] = v[6];
    end
  end

  always_comb begin
    for (int w = 0; w < BLK_WORDS; w++) pblk[w] = 32'h0;
    pb = 8'h00;
    for (int i = 0; i < BLK_BYTES; i++) begin
      pb = blk[i/4][31 - 8*(i%4) -: 8];
      if (i > int'(rem)) pb = 8'h00;
      else if (i == int'(rem)) pb = 8'h80;
      if (int'(rem) < LEN_BYTE0 && i >= LEN_BYTE0) pb = bitlen[63 - 8*(i - LEN_BYTE0) -: 8];
      pblk[i/4][31 - 8*(i%4) -: 8] = pb;
    end
  end

  always_comb begin
    hraw = st[addr[4:2]];
    hw = hraw;
    if ((sha1 && addr[4:2] >= 3'd5) || (mode == 2'd1 && done && addr[4:2] == 3'd7)) hw = 32'h0;
    rdata = 32'h0;
    if (sel_ctrl)      rdata = {21'd0, out_en, fifo_en, 3'd0, mode, big, in_en, fin, running};
    else if (sel_cnt)  rdata = count;
    else if (sel_hash) rdata = big ? hw : bswap(hw);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BLK_WORDS; i++) blk[i] <= 32'h0;
      for (int i = 0; i < ST_WORDS; i++) begin
        st[i] <= 32'h0;
        v[i]  <= 32'h0;
      end
      count   <= 32'h0;
      rnd     <= 7'd0;
      running <= 1'b0;
      fin     <= 1'b0;
      extra   <= 1'b0;
      done    <= 1'b0;
      mode    <= 2'd0;
      big     <= 1'b0;
      in_en   <= 1'b0;
      fifo_en <= 1'b0;
      out_en  <= 1'b0;
    end else if (running) begin
      for (int i = 0; i < BLK_WORDS - 1; i++) blk[i] <= blk[i+1];
      blk[BLK_WORDS-1] <= wnew;
      v   <= vn;
      rnd <= rnd + 7'd1;
      if (last) begin
        for (int i = 0; i < ST_WORDS; i++) st[i] <= st[i] + vn[i];
        if (fin && extra) begin
          extra <= 1'b0;
          rnd   <= 7'd0;
          for (int i = 0; i < ST_WORDS; i++) v[i] <= st[i] + vn[i];
          for (int i = 0; i < BLK_WORDS - 2; i++) blk[i] <= 32'h0;
          blk[BLK_WORDS-2] <= bitlen[63:32];
          blk[BLK_WORDS-1] <= bitlen[31:0];
        end else begin
          running <= 1'b0;
          if (fin) begin
            fin  <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end else if (wr_en) begin
      if (sel_ctrl) begin
        in_en   <= wdata[2];
        big     <= wdata[3];
        mode    <= wdata[5:4];
        fifo_en <= wdata[9];
        out_en  <= wdata[10];
        if (wdata[0]) begin
          done <= 1'b0;
          if (count == 32'h0)
            for (int i = 0; i < ST_WORDS; i++) st[i] <= iv_word(wdata[5:4], i);
          if (wdata[1]) begin
            for (int i = 0; i < ST_WORDS; i++)
              v[i] <= (count == 32'h0) ? iv_word(wdata[5:4], i) : st[i];
            blk     <= pblk;
            extra   <= int'(rem) >= LEN_BYTE0;
            fin     <= 1'b1;
            running <= 1'b1;
            rnd     <= 7'd0;
          end
        end
      end else if (sel_cnt) begin
        count <= wdata;
      end else if (sel_hash) begin
        st[addr[4:2]] <= big ? wdata : bswap(wdata);
        done <= 1'b0;
      end else if (sel_win) begin
        blk[count[5:2]] <= wdata;
        count <= count + 32'd4;
        done  <= 1'b0;
        if (count[5:2] == 4'hf) begin
          v       <= st;
          running <= 1'b1;
          rnd     <= 7'd0;
        end
      end
    end
  end
endmodule

// File: rtl/sha_engine_chk.sv
module sha_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        running,
  input logic        fin,
  input logic        sha1,
  input logic [6:0]  rnd,
  input logic [31:0] count,
  input logic        in_dma_req,
  input logic        out_dma_req
);
  a_r4_round_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (rnd < (sha1 ? 7'd80 : 7'd64)));

  a_r4_first_round: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> rnd == 7'd0);

  a_r5_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(count));

  a_r6_final_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> running);

  a_r11_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_dma_req |-> !running);

  a_r11_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
    out_dma_req |-> !running);
endmodule

bind sha_engine sha_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .fin(fin), .sha1(sha1),
  .rnd(rnd), .count(count), .in_dma_req(in_dma_req), .out_dma_req(out_dma_req)
);

// File: tb/test_sha_engine.sv
`timescale 1ns/1ps
module test_sha_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic in_dma_req, out_dma_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] msg [128];
  int msg_len = 0;
  logic [31:0] dig [8];
  logic [31:0] da [8];
  logic [31:0] sv [8];
  logic [31:0] rv, cnt_saved;
  int busy;

  always #2 clk = ~clk;

  sha_engine i_sha_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .in_dma_req(in_dma_req), .out_dma_req(out_dma_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    do bus_rd(8'h00, c); while (c[0]);
  endtask

  function automatic logic [31:0] cfg(input int m);
    return (m == 2 ? 32'h20 : (m == 1 ? 32'h10 : 32'h0)) | 32'h8 | 32'h200;
  endfunction

  function automatic logic [31:0] bsw(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] mword(input int w);
    logic [31:0] r = 32'h0;
    for (int b = 0; b < 4; b++)
      if (4*w + b < msg_len) r[31 - 8*b -: 8] = msg[4*w + b];
    return r;
  endfunction

  function automatic logic [255:0] expect_dig(input int m, input int k);
    case (m*3 + k)
      0: return 256'he3b0c442_98fc1c14_9afbf4c8_996fb924_27ae41e4_649b934c_a495991b_7852b855;
      1: return 256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad;
      2: return 256'h248d6a61_d20638b8_e5c02693_0c3e6039_a33ce459_64ff2167_f6ecedd4_19db06c1;
      3: return 256'hd14a028c_2a3a2bc9_476102bb_288234c4_15a2b01f_828ea62a_c5b3e42f_00000000;
      4: return 256'h23097d22_3405d822_8642a477_bda255b3_2aadbce4_bda0b3f7_e36c9da7_00000000;
      5: return 256'h75388b16_512776cc_5dba5da1_fd890150_b0c6455c_b4f58b19_52522525_00000000;
      6: return 256'hda39a3ee_5e6b4b0d_3255bfef_95601890_afd80709_00000000_00000000_00000000;
      7: return 256'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d_00000000_00000000_00000000;
      default: return 256'h84983e44_1c3bd26e_baae4aa1_f95129e5_e54670f1_00000000_00000000_00000000;
    endcase
  endfunction

  task automatic set_msg(input int k);
    for (int i = 0; i < 128; i++) msg[i] = 8'h00;
    if (k == 0) msg_len = 0;
    else if (k == 1) begin
      msg_len = 3; msg[0] = 8'h61; msg[1] = 8'h62; msg[2] = 8'h63;
    end else if (k == 2) begin
      msg_len = 56;
      for (int j = 0; j < 14; j++)
        for (int b = 0; b < 4; b++) msg[4*j + b] = 8'(8'h61 + j + b);
    end else begin
      msg_len = 128;
      for (int i = 0; i < 128; i++) msg[i] = 8'((i*13 + 7) & 255);
    end
  endtask

  task automatic begin_hash(input int m);
    bus_wr(8'h04, 32'h0);
    bus_wr(8'h00, cfg(m) | 32'h1);
  endtask

  task automatic feed(input int from_w, input int to_w);
    for (int w = from_w; w <= to_w; w++) begin
      wait_idle();
      bus_wr(8'(8'h80 | ((w*28 + w%4) % 64)), mword(w));
    end
  endtask

  task automatic finish_hash(input int m);
    int blocks;
    wait_idle();
    if (msg_len % 4 != 0) bus_wr(8'h04, 32'(msg_len));
    bus_wr(8'h00, cfg(m) | 32'h3);
    addr = 8'h00;
    #1;
    chk("R6 final flag reads 1", {31'd0, rdata[1]}, 32'h1);
    busy = 0;
    while (rdata[0]) begin
      busy++;
      @(negedge clk);
      #1;
    end
    blocks = ((msg_len % 64) >= 56) ? 2 : 1;
    chk("R4 final busy cycles", 32'(busy), 32'(blocks * (m == 2 ? 80 : 64)));
    for (int i = 0; i < 8; i++) bus_rd(8'(8'h40 + 4*i), dig[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_rd(8'h00, rv); chk("R1 control after reset", rv, 32'h0);
    bus_rd(8'h04, rv); chk("R1 count after reset", rv, 32'h0);
    bus_rd(8'h40, rv); chk("R1 hash word 0 after reset", rv, 32'h0);
    bus_rd(8'h5c, rv); chk("R1 hash word 7 after reset", rv, 32'h0);
    chk("R1 request flags after reset", {30'd0, in_dma_req, out_dma_req}, 32'h0);

    begin_hash(2);
    bus_rd(8'h40, rv); chk("R2 SHA-1 initial word 0", rv, 32'h67452301);
    bus_rd(8'h54, rv); chk("R2 R7 SHA-1 word 5 reads zero", rv, 32'h0);
    begin_hash(1);
    bus_rd(8'h40, rv); chk("R2 SHA-224 initial word 0", rv, 32'hc1059ed8);
    bus_rd(8'h5c, rv); chk("R2 SHA-224 initial word 7", rv, 32'hbefa4fa4);

    for (int m = 0; m < 3; m++)
      for (int k = 0; k < 3; k++) begin
        logic [255:0] e;
        set_msg(k);
        begin_hash(m);
        feed(0, (msg_len + 3)/4 - 1);
        finish_hash(m);
        e = expect_dig(m, k);
        for (int i = 0; i < 8; i++)
          chk($sformatf("R6 R7 mode %0d msg %0d word %0d", m, k, i), dig[i], e[255 - 32*i -: 32]);
        if (k == 1) begin
          bus_rd(8'h04, rv); chk("R9 count kept after final", rv, 32'd3);
        end
      end

    bus_wr(8'h00, cfg(2) | 32'h404);
    chk("R11 input request with bits 2 and 9", {31'd0, in_dma_req}, 32'h1);
    chk("R11 output request with digest waiting", {31'd0, out_dma_req}, 32'h1);
    bus_wr(8'h00, (cfg(2) & ~32'h200) | 32'h404);
    chk("R11 input request needs bit 9", {31'd0, in_dma_req}, 32'h0);
    bus_wr(8'h80, 32'h0);
    chk("R11 window write clears digest", {31'd0, out_dma_req}, 32'h0);

    set_msg(3);
    begin_hash(0);
    feed(0, 14);
    bus_rd(8'h04, rv); chk("R3 count after 15 words", rv, 32'd60);
    bus_wr(8'hbd, mword(15));
    addr = 8'h00;
    #1;
    busy = 0;
    while (rdata[0]) begin
      busy++;
      @(negedge clk);
      #1;
    end
    chk("R4 automatic block busy cycles", 32'(busy), 32'd64);
    feed(16, 31);
    finish_hash(0);
    for (int i = 0; i < 8; i++) da[i] = dig[i];

    begin_hash(0);
    feed(0, 15);
    bus_wr(8'h80, 32'hdeadbeef);
    bus_wr(8'h00, cfg(0) | 32'h3);
    wait_idle();
    bus_rd(8'h04, rv); chk("R5 count unchanged by busy writes", rv, 32'd64);
    bus_rd(8'h00, rv); chk("R5 control write ignored while busy", {31'd0, rv[1]}, 32'h0);
    cnt_saved = rv;
    bus_rd(8'h04, cnt_saved);
    for (int i = 0; i < 8; i++) bus_rd(8'(8'h40 + 4*i), sv[i]);

    set_msg(1);
    begin_hash(0);
    feed(0, 0);
    finish_hash(0);
    chk("R6 interleaved abc word 0", dig[0], 32'hba7816bf);

    set_msg(3);
    bus_wr(8'h04, cnt_saved);
    for (int i = 0; i < 8; i++) bus_wr(8'(8'h40 + 4*i), sv[i]);
    bus_rd(8'h40, rv); chk("R10 restored word 0 readback", rv, sv[0]);
    feed(16, 31);
    finish_hash(0);
    for (int i = 0; i < 8; i++)
      chk($sformatf("R10 resumed digest word %0d", i), dig[i], da[i]);

    bus_wr(8'h00, cfg(0) & ~32'h8);
    bus_rd(8'h40, rv); chk("R8 byte-reversed read word 0", rv, bsw(da[0]));
    bus_rd(8'h5c, rv); chk("R8 byte-reversed read word 7", rv, bsw(da[7]));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule